// File: doc/BRIEF.md
# Serial Flash Status and Write-Protect Unit

This unit holds the status byte of a serial NOR flash device and answers the status-related commands that arrive on an SPI mode-0 slave port. Those commands are set latch, clear latch, read status and write status. The SPI pins are oversampled in the system clock domain. A frame is decoded when chip select returns high. Read-status data is shifted out MSB first, and a fresh copy of the byte is sent for every further 8 clocks while chip select stays low. This lets a host poll the busy flag in real time.

Writes are protected in three ways. First, a write-enable latch must be set before a status write is accepted. Second, a protection mode freezes the status register while its lock bit is 1 and the active-low write-protect pin is driven low. Third, an accepted status write holds the busy flag for a programmable number of system clocks. A companion program/erase engine receives a permit output, which is the latch gated by busy. It also receives a combinational lock flag for the address it presents. The engine reports its own activity back through a busy input. The latch clears when either kind of write cycle ends.

Top module: `flash_status_unit`

## Requirements
- R1: After reset the status byte is 0x00, `pe_allow_o` and `busy_o` are 0. Status byte layout: bit0 busy (WIP), bit1 write-enable latch (WEL), bits 4:2 protect level BP[2:0], bits 6:5 always 0, bit7 status lock (SRWD).
- R2: After opcode 0x05, MISO carries the status byte MSB first, changing after falling SCK. A newly sampled byte is sent every 8 clocks while chip select stays low. MISO is 0 while chip select is high.
- R3: Opcode 0x06 sets WEL and opcode 0x04 clears it. Each takes effect only when chip select rises after exactly 8 SCK clocks.
- R4: A status write (opcode 0x01 plus one data byte) is ignored when WEL is 0.
- R5: A status write commits only when chip select rises after exactly 16 SCK clocks. Any other length leaves the status unchanged, including WEL.
- R6: An accepted status write loads SRWD from data bit7 and BP from data bits 4:2, and ignores the other data bits. It then holds WIP (and `busy_o`) high for exactly WR_CYCLES system clocks.
- R7: While SRWD is 1 and `wp_ni` is 0, a status write is rejected. SRWD, BP and WEL keep their values.
- R8: WEL clears when an accepted write cycle ends: the end of the status-write busy period, or a falling edge of `pe_busy_i`.
- R9: `pe_allow_o` is 1 exactly when WEL is 1 and WIP is 0.
- R10: `region_locked_o` is 0 for BP=0 and 1 for every address when BP=7. For BP=1..6 it is 1 exactly when the address lies in the upper 1/2^(7-BP) of the address space.
- R11: `pe_busy_i` high makes WIP 1, both in status bit0 and on `busy_o`. While WIP is 1, opcodes 0x06, 0x04 and 0x01 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | SPI serial clock, idles low |
| cs_ni | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | SPI data in |
| miso_o | output | 1 | SPI data out |
| wp_ni | input | 1 | Write-protect pin, active low |
| pe_busy_i | input | 1 | Program/erase engine busy |
| addr_i | input | ADDR_W | Address queried for protection |
| pe_allow_o | output | 1 | Program/erase command permitted |
| region_locked_o | output | 1 | Queried address is protected |
| busy_o | output | 1 | Write in progress |

## Verification
A wrong latch value shows on `pe_allow_o` in the cycle after the frame ends. It also shows in bit1 of the next status byte, at most 8 SCK clocks later. Corrupted protect bits change `region_locked_o` in the same cycle, so a full sweep of addresses over all eight levels exposes any error in the map or in the stored level. A timer fault appears as a wrong count of `busy_o` cycles. Polling with a multi-byte read catches a status byte that is stale instead of freshly sampled.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam int BP_W = 3;

  typedef struct packed {
    logic            srwd;
    logic [1:0]      rsvd;
    logic [BP_W-1:0] bp;
    logic            wel;
    logic            wip;
  } fsr_status_t;
endpackage

// File: rtl/fsr_spi_rx.sv
module fsr_spi_rx
  import fsr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sck_i,
  input  logic            cs_ni,
  input  logic            mosi_i,
  input  fsr_status_t     status_i,
  output logic [7:0]      opcode_o,
  output logic            wd_srwd_o,
  output logic [BP_W-1:0] wd_bp_o,
  output logic            frame_end_o,
  output logic            len8_o,
  output logic            len16_o,
  output logic            miso_o
);
  logic [SYNC_STAGES-1:0] sck_p, cs_p, mosi_p;
  logic sck_q, cs_q, sck_s, cs_s, mosi_s;
  logic sck_rise, sck_fall;
  logic [7:0] shreg_q;
  logic [2:0] bit_idx_q;
  logic [1:0] byte_cnt_q;   // completed bytes, saturates at 3
  logic [6:0] out_sr_q;
  logic       miso_q;
  logic       rdsr;

  assign sck_s  = sck_p[SYNC_STAGES-1];
  assign cs_s   = cs_p[SYNC_STAGES-1];
  assign mosi_s = mosi_p[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_p  <= '0;
      cs_p   <= '1;
      mosi_p <= '0;
      sck_q  <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sck_p  <= {sck_p[SYNC_STAGES-2:0], sck_i};
      cs_p   <= {cs_p[SYNC_STAGES-2:0], cs_ni};
      mosi_p <= {mosi_p[SYNC_STAGES-2:0], mosi_i};
      sck_q  <= sck_s;
      cs_q   <= cs_s;
    end
  end

  assign sck_rise    = sck_s & ~sck_q & ~cs_s;
  assign sck_fall    = ~sck_s & sck_q & ~cs_s;
  assign frame_end_o = cs_s & ~cs_q;
  assign rdsr        = (byte_cnt_q != 2'd0) && (opcode_o == OP_RDSR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q    <= '0;
      bit_idx_q  <= '0;
      byte_cnt_q <= '0;
      opcode_o   <= '0;
      out_sr_q   <= '0;
      miso_q     <= 1'b0;
    end else if (cs_s) begin
      bit_idx_q  <= '0;
      byte_cnt_q <= '0;
      opcode_o   <= '0;
      miso_q     <= 1'b0;
    end else begin
      if (sck_rise) begin
        shreg_q   <= {shreg_q[6:0], mosi_s};
        bit_idx_q <= bit_idx_q + 3'd1;
        if (bit_idx_q == 3'd7) begin
          if (byte_cnt_q != 2'd3) byte_cnt_q <= byte_cnt_q + 2'd1;
          if (byte_cnt_q == 2'd0) opcode_o <= {shreg_q[6:0], mosi_s};
        end
      end
      if (sck_fall && rdsr) begin
        if (bit_idx_q == 3'd0) begin
          // byte boundary: take a fresh snapshot of the status
          miso_q   <= status_i[7];
          out_sr_q <= status_i[6:0];
        end else begin
          miso_q   <= out_sr_q[6];
          out_sr_q <= {out_sr_q[5:0], 1'b0};
        end
      end
    end
  end

  assign len8_o    = (byte_cnt_q == 2'd1) && (bit_idx_q == 3'd0);
  assign len16_o   = (byte_cnt_q == 2'd2) && (bit_idx_q == 3'd0);
  assign wd_srwd_o = shreg_q[7];
  assign wd_bp_o   = shreg_q[4:2];
  assign miso_o    = miso_q;
endmodule

// File: rtl/fsr_sr_core.sv
module fsr_sr_core
  import fsr_pkg::*;
#(
  parameter int unsigned WR_CYCLES = 1000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            frame_end_i,
  input  logic            len8_i,
  input  logic            len16_i,
  input  logic [7:0]      opcode_i,
  input  logic            wd_srwd_i,
  input  logic [BP_W-1:0] wd_bp_i,
  input  logic            wp_ni,
  input  logic            pe_busy_i,
  output fsr_status_t     status_o,
  output logic [BP_W-1:0] bp_o,
  output logic            pe_allow_o,
  output logic            busy_o
);
  localparam int TMR_W = $clog2(WR_CYCLES + 1);

  logic [TMR_W-1:0] tmr_q;
  logic [BP_W-1:0]  bp_q;
  logic srwd_q, wel_q, pe_busy_q;
  logic wip, hpm, do_wren, do_wrdi, do_wrsr, wr_done;

  assign wip     = (tmr_q != '0) | pe_busy_i;
  assign hpm     = srwd_q & ~wp_ni;
  assign do_wren = frame_end_i & len8_i & (opcode_i == OP_WREN) & ~wip;
  assign do_wrdi = frame_end_i & len8_i & (opcode_i == OP_WRDI) & ~wip;
  assign do_wrsr = frame_end_i & len16_i & (opcode_i == OP_WRSR) & wel_q & ~wip & ~hpm;
  assign wr_done = (tmr_q == TMR_W'(1)) | (pe_busy_q & ~pe_busy_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q     <= '0;
      bp_q      <= '0;
      srwd_q    <= 1'b0;
      wel_q     <= 1'b0;
      pe_busy_q <= 1'b0;
    end else begin
      pe_busy_q <= pe_busy_i;
      if (do_wrsr) begin
        srwd_q <= wd_srwd_i;
        bp_q   <= wd_bp_i;
        tmr_q  <= TMR_W'(WR_CYCLES);
      end else if (tmr_q != '0) begin
        tmr_q <= tmr_q - TMR_W'(1);
      end
      if (wr_done)      wel_q <= 1'b0;
      else if (do_wren) wel_q <= 1'b1;
      else if (do_wrdi) wel_q <= 1'b0;
    end
  end

  always_comb begin
    status_o.srwd = srwd_q;
    status_o.rsvd = 2'b00;
    status_o.bp   = bp_q;
    status_o.wel  = wel_q;
    status_o.wip  = wip;
  end
  assign bp_o       = bp_q;
  assign pe_allow_o = wel_q & ~wip;
  assign busy_o     = wip;

  // R4: protected fields only change when the latch was set
  a_r4_wel_gates_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({srwd_q, bp_q}) |-> $past(wel_q));
  // R7: protection mode freezes the register
  a_r7_hpm_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srwd_q && !wp_ni) |=> $stable({srwd_q, bp_q}));
  // R5: a frame of wrong length leaves the register alone
  a_r5_len_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end_i && !len16_i) |=> $stable({srwd_q, bp_q}));
  // R6: every register update starts a full busy period
  a_r6_busy_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({srwd_q, bp_q}) |-> (tmr_q == TMR_W'(WR_CYCLES)));
  // R8: latch is clear once the status-write busy period ends
  a_r8_wel_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tmr_q != '0) |-> !wel_q);
endmodule

// File: rtl/fsr_prot_map.sv
module fsr_prot_map
  import fsr_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [BP_W-1:0]   bp_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              locked_o
);
  localparam int NLEV = (1 << BP_W) - 1;

  always_comb begin
    locked_o = 1'b0;
    if (bp_i == '1) begin
      locked_o = 1'b1;
    end else if (bp_i != '0) begin
      for (int k = 1; k < NLEV; k++) begin
        if (k == NLEV - int'(bp_i)) begin
          // upper 1/2^k of the space: top k address bits all ones
          locked_o = ((addr_i & ~({ADDR_W{1'b1}} >> k)) == ~({ADDR_W{1'b1}} >> k));
        end
      end
    end
  end

  // R10: the highest address is locked at every nonzero level
  always_comb begin
    if ((bp_i != '0) && (&addr_i))
      a_r10_top_addr_locked: assert (locked_o);
  end
endmodule

// File: rtl/flash_status_unit.sv
module flash_status_unit
  import fsr_pkg::*;
#(
  parameter int          ADDR_W      = 24,
  parameter int unsigned WR_CYCLES   = 1000,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  output logic              miso_o,
  input  logic              wp_ni,
  input  logic              pe_busy_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              pe_allow_o,
  output logic              region_locked_o,
  output logic              busy_o
);
  fsr_status_t     status;
  logic [7:0]      opcode;
  logic            wd_srwd, frame_end, len8, len16;
  logic [BP_W-1:0] wd_bp, bp;

  fsr_spi_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk_i, .rst_ni, .sck_i, .cs_ni, .mosi_i,
    .status_i    (status),
    .opcode_o    (opcode),
    .wd_srwd_o   (wd_srwd),
    .wd_bp_o     (wd_bp),
    .frame_end_o (frame_end),
    .len8_o      (len8),
    .len16_o     (len16),
    .miso_o
  );

  fsr_sr_core #(.WR_CYCLES(WR_CYCLES)) u_core (
    .clk_i, .rst_ni,
    .frame_end_i (frame_end),
    .len8_i      (len8),
    .len16_i     (len16),
    .opcode_i    (opcode),
    .wd_srwd_i   (wd_srwd),
    .wd_bp_i     (wd_bp),
    .wp_ni,
    .pe_busy_i,
    .status_o    (status),
    .bp_o        (bp),
    .pe_allow_o,
    .busy_o
  );

  fsr_prot_map #(.ADDR_W(ADDR_W)) u_map (
    .bp_i     (bp),
    .addr_i,
    .locked_o (region_locked_o)
  );
endmodule

// File: tb/flash_status_unit_tb.sv
module flash_status_unit_tb_top;
  localparam int AW = 8;
  localparam int NCYC = 300;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, wp_n = 1'b1, pe_busy = 1'b0;
  logic [AW-1:0] addr = '0;
  logic miso, pe_allow, locked, busy;
  int n_chk = 0, n_fail = 0, busy_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  flash_status_unit #(.ADDR_W(AW), .WR_CYCLES(NCYC)) dut_i (
    .clk_i(clk), .rst_ni, .sck_i(sck), .cs_ni(cs_n), .mosi_i(mosi), .miso_o(miso),
    .wp_ni(wp_n), .pe_busy_i(pe_busy), .addr_i(addr), .pe_allow_o(pe_allow),
    .region_locked_o(locked), .busy_o(busy));

  always @(negedge clk) if (busy) busy_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic frame(input int nbits, input logic [63:0] tx, output logic [63:0] rx);
    rx = '0;
    @(negedge clk); cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = nbits - 1; i >= 0; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx = {rx[62:0], miso};
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (4 * HALF) @(negedge clk);
  endtask

  task automatic cmd8(input logic [7:0] op);
    logic [63:0] r;
    frame(8, {56'h0, op}, r);
  endtask

  task automatic wrsr(input logic [7:0] d);
    logic [63:0] r;
    frame(16, {48'h0, 8'h01, d}, r);
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [63:0] r;
    frame(16, 64'h0500, r);
    s = r[7:0];
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic logic model_lock(input int bp, input int a);
    if (bp == 0) return 1'b0;
    if (bp == 7) return 1'b1;
    return a >= (256 - (256 >> (7 - bp)));
  endfunction

  initial begin
    logic [7:0] s;
    logic [63:0] r;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    chk("R1 allow after reset", pe_allow, 0);
    chk("R1 busy after reset", busy, 0);
    chk("R2 miso idle", miso, 0);
    rdsr(s); chk("R1 status after reset", s, 8'h00);

    cmd8(8'h06); rdsr(s); chk("R3 wren sets latch", s, 8'h02);
    chk("R9 allow with latch", pe_allow, 1);
    cmd8(8'h04); rdsr(s); chk("R3 wrdi clears latch", s, 8'h00);
    chk("R9 allow without latch", pe_allow, 0);
    frame(16, 64'h0600, r); rdsr(s); chk("R3 wren of 16 clocks ignored", s, 8'h00);

    busy_cnt = 0;
    wrsr(8'h9C); wait_idle(); rdsr(s);
    chk("R4 write without latch ignored", s, 8'h00);
    chk("R4 no busy period", busy_cnt, 0);

    cmd8(8'h06);
    frame(15, 64'h019C >> 1, r); rdsr(s); chk("R5 15-clock write ignored", s, 8'h02);
    frame(24, 64'h019C00, r); rdsr(s); chk("R5 24-clock write ignored", s, 8'h02);

    // accepted write, other data bits set to prove they are dropped; poll while busy
    busy_cnt = 0;
    wrsr(8'hFF);
    frame(40, 64'h05 << 32, r);
    chk("R2 R6 first polled byte busy", r[31:24], 8'h9F);
    chk("R8 R2 last polled byte idle", r[7:0], 8'h9C);
    wait_idle();
    chk("R6 busy length", busy_cnt, NCYC);

    wp_n = 1'b0;
    cmd8(8'h06); rdsr(s); chk("R7 latch set in protect mode", s, 8'h9E);
    busy_cnt = 0;
    wrsr(8'h00); wait_idle(); rdsr(s);
    chk("R7 write rejected", s, 8'h9E);
    chk("R7 no busy period", busy_cnt, 0);
    wp_n = 1'b1;
    repeat (2) @(negedge clk);
    wrsr(8'h00); wait_idle(); rdsr(s); chk("R7 write accepted with pin high", s, 8'h00);

    for (int bp = 0; bp < 8; bp++) begin
      cmd8(8'h06);
      wrsr(8'(bp << 2)); wait_idle();
      rdsr(s); chk("R6 protect level stored", s, 32'(bp << 2));
      for (int a = 0; a < 256; a++) begin
        addr = 8'(a);
        @(negedge clk);
        chk("R10 region lock", locked, model_lock(bp, a));
      end
    end

    cmd8(8'h06);
    chk("R9 allow before engine busy", pe_allow, 1);
    pe_busy = 1'b1;
    @(negedge clk);
    chk("R11 busy_o follows engine", busy, 1);
    chk("R9 allow blocked while busy", pe_allow, 0);
    rdsr(s); chk("R11 status shows busy", s, 8'h1F);
    cmd8(8'h04); rdsr(s); chk("R11 wrdi ignored while busy", s, 8'h1F);
    pe_busy = 1'b0;
    repeat (2) @(negedge clk);
    rdsr(s); chk("R8 latch cleared at engine done", s, 8'h1C);
    chk("R9 allow after engine done", pe_allow, 0);
    chk("R2 miso idle at end", miso, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1 act=timeout exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule